// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations and looks them up all at once. A request brings a 32-bit virtual address, an address-space tag and the kind of access (write or not, user or supervisor). Every stored entry is compared with the upper 20 bits of the address and with the tag. The registered answer appears one cycle later. It is one of three outcomes: a hit that carries the physical address, a miss that tells the surrounding logic to walk the page tables, or a protection fault.

After a walk, the walker writes one translation back through the fill port. The new translation takes a free slot when one exists. Otherwise it replaces the entry that was used least recently. A single translation can be invalidated when its rights change, and the whole buffer can be flushed. Entries carry the address-space tag, so a context switch needs no flush.

Lookups and fills are valid/ready streams. A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` drops while a fill is offered, and it drops while a response is waiting on a low `rsp_ready`. A stalled response holds all its fields. `fill_ready` drops in any cycle in which a flush or an invalidate is asserted. The invalidate and flush inputs are plain single-cycle strobes.

Top module: `xlat_buffer`

## Requirements
- R1: An accepted lookup whose page number and tag match a valid entry that permits the access gives, on the next cycle, `rsp_valid`=1 and `rsp_hit`=1. The physical address is then {entry frame number, address bits 11:0}.
- R2: A lookup matches only an entry whose page number and address-space tag are both equal to the request. With no match the response has `rsp_miss`=1 and a zero address.
- R3: A matching lookup raises `rsp_fault` instead of `rsp_hit` in two cases: a write to an entry without write permission, or a user access to an entry without user permission. The address is then zero. Every response has exactly one of hit, miss or fault set.
- R4: While any slot is free, an accepted fill evicts no valid translation.
- R5: When every slot is valid, a fill replaces the translation least recently touched. A touch is any accepted lookup that matched the entry (hit or fault) or any fill that wrote it.
- R6: A fill whose page number and tag equal a valid entry overwrites that entry, and no second copy is made.
- R7: An invalidate strobe clears only the valid entry that matches its page number and tag. All other entries stay usable.
- R8: A flush strobe clears every entry in one cycle, so every later lookup misses until new fills arrive.
- R9: `req_ready` is low while `fill_valid` is high. `fill_ready` is low while `flush_en` or `inv_en` is high. Out of reset both ready outputs are high and `rsp_valid` is low.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay unchanged and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space tag of the request |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation returned |
| rsp_miss | output | 1 | No entry matched; table walk needed |
| rsp_fault | output | 1 | Entry matched but access not permitted |
| rsp_paddr | output | 32 | Physical address on hit, else zero |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 20 | Page number of the fill |
| fill_asid | input | 8 | Address-space tag of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_wr | input | 1 | Entry allows writes |
| fill_usr | input | 1 | Entry allows user access |
| inv_en | input | 1 | Invalidate strobe |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 8 | Address-space tag to invalidate |
| flush_en | input | 1 | Clear all entries |

## Verification
Some internal faults show up at the ports. A corrupted recency order leaves the wrong translation in place, and this appears as an unexpected miss on the first lookup after the next fill into a full buffer. A duplicated or stale entry appears as an old frame number, or as a hit after an invalidate, on the very next lookup. The bench keeps its own reference model, which uses last-use timestamps. It compares every outcome and address against that model: across full fill sweeps, eviction sweeps over twice the capacity, permission combinations, overwrite, invalidate, flush and a stalled response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int ASID_W = 8;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic              usr;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } xent_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int  N  = 16,
  localparam int IW = $clog2(N)
) (
  input  xent_t [N-1:0]     ents,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic [N-1:0]      vec,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = ents[g].valid && (ents[g].vpn == key_vpn) && (ents[g].asid == key_asid);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign hit = |vec;
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int  N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim
);
  // age 0 = most recent, N-1 = oldest; ages always form a permutation
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + IW'(1);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) oldest[i] = (age[i] == IW'(N - 1));
  end

  always_comb begin
    victim = '0;
    if (!(&valid)) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!valid[i]) victim = IW'(i);
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (oldest[i]) victim = IW'(i);
      end
    end
  end

  // R5: exactly one entry is the replacement candidate at any time
  p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int  ENTRIES = 16,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_wr,
  input  logic              fill_usr,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush_en
);
  xent_t [ENTRIES-1:0] tbl;
  logic  [ENTRIES-1:0] vld;
  logic  [ENTRIES-1:0] lk_vec, fl_vec, iv_vec;
  logic                lk_hit, fl_hit, iv_hit;
  logic  [IW-1:0]      lk_idx, fl_idx, iv_idx, victim, slot, touch_idx;
  logic                req_fire, fill_fire, denied, touch;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld[g] = tbl[g].valid;
  end

  xlat_cam #(.N(ENTRIES)) u_lk_cam (.ents(tbl), .key_vpn(req_vaddr[VA_W-1:OFF_W]), .key_asid(req_asid),
                                    .vec(lk_vec), .hit(lk_hit), .idx(lk_idx));
  xlat_cam #(.N(ENTRIES)) u_fl_cam (.ents(tbl), .key_vpn(fill_vpn), .key_asid(fill_asid),
                                    .vec(fl_vec), .hit(fl_hit), .idx(fl_idx));
  xlat_cam #(.N(ENTRIES)) u_iv_cam (.ents(tbl), .key_vpn(inv_vpn), .key_asid(inv_asid),
                                    .vec(iv_vec), .hit(iv_hit), .idx(iv_idx));

  assign req_ready  = (!rsp_valid || rsp_ready) && !fill_valid;
  assign fill_ready = !flush_en && !inv_en;
  assign req_fire   = req_valid && req_ready;
  assign fill_fire  = fill_valid && fill_ready;
  assign slot       = fl_hit ? fl_idx : victim;
  assign denied     = (req_write && !tbl[lk_idx].wr) || (req_user && !tbl[lk_idx].usr);
  assign touch      = fill_fire || (req_fire && lk_hit);
  assign touch_idx  = fill_fire ? slot : lk_idx;

  xlat_lru #(.N(ENTRIES)) u_lru (.clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
                                 .valid(vld), .victim(victim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (flush_en) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i].valid <= 1'b0;
    end else begin
      if (inv_en && iv_hit) tbl[iv_idx].valid <= 1'b0;
      if (fill_fire) begin
        tbl[slot] <= '{valid: 1'b1, wr: fill_wr, usr: fill_usr, asid: fill_asid,
                       vpn: fill_vpn, pfn: fill_pfn};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_hit && !denied;
      rsp_miss  <= !lk_hit;
      rsp_fault <= lk_hit && denied;
      rsp_paddr <= (lk_hit && !denied) ? {tbl[lk_idx].pfn, req_vaddr[OFF_W-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R6: no two valid entries ever share page number and tag
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_vec) && $onehot0(fl_vec));
  // R3: every response carries exactly one outcome
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  // R10: stalled response is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable({rsp_hit, rsp_miss, rsp_fault}));
  // R8: flush leaves nothing valid
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n) flush_en |=> vld == '0);
  // R7: the invalidated entry is gone next cycle
  p_inv_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (vld & $past(iv_vec)) == '0);
endmodule

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_user = 0, rsp_ready = 1;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_ready;
  logic [31:0] rsp_paddr;
  logic fill_valid = 0, fill_wr = 0, fill_usr = 0, inv_en = 0, flush_en = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
  logic [7:0]  fill_asid = '0, inv_asid = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlat_buffer #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_asid(req_asid), .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_wr(fill_wr), .fill_usr(fill_usr),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush_en(flush_en));

  // reference model: last-use timestamps
  bit          mv [N];
  logic [19:0] mvpn [N];
  logic [7:0]  masid [N];
  logic [19:0] mpfn [N];
  bit          mwr [N];
  bit          musr [N];
  int          mst [N];
  int          now = 0;

  function automatic int mfind(input logic [19:0] vpn, input logic [7:0] asid);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn && masid[i] == asid) return i;
    return -1;
  endfunction

  function automatic logic [19:0] key(input int i);
    return 20'h01000 + 20'(i * 291);
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [7:0] asid,
                      input bit wr, input bit usr, input string rq);
    int k;
    logic [1:0] ecode, acode;
    logic [31:0] epa;
    k = mfind(vpn, asid);
    if (k < 0) begin ecode = 2; epa = 0; end
    else if ((wr && !mwr[k]) || (usr && !musr[k])) begin ecode = 3; epa = 0; end
    else begin ecode = 1; epa = {mpfn[k], off}; end
    if (k >= 0) begin now++; mst[k] = now; end
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_asid = asid; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 0;
    acode = rsp_hit ? 2'd1 : rsp_miss ? 2'd2 : rsp_fault ? 2'd3 : 2'd0;
    check(rsp_valid && acode == ecode && rsp_paddr == epa, rq,
          {rsp_valid, acode, rsp_paddr}, {1'b1, ecode, epa});
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                      input bit wr, input bit usr);
    int k, best;
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_wr = wr; fill_usr = usr;
    @(negedge clk);
    fill_valid = 0;
    k = mfind(vpn, asid);
    if (k < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) k = i;
    end
    if (k < 0) begin
      best = 0;
      for (int i = 1; i < N; i++) if (mst[i] < mst[best]) best = i;
      k = best;
    end
    mv[k] = 1; mvpn[k] = vpn; masid[k] = asid; mpfn[k] = pfn; mwr[k] = wr; musr[k] = usr;
    now++; mst[k] = now;
  endtask

  task automatic inval(input logic [19:0] vpn, input logic [7:0] asid);
    int k;
    @(negedge clk);
    inv_en = 1; inv_vpn = vpn; inv_asid = asid;
    #1 check(fill_ready == 0, "R9 fill_ready during invalidate", fill_ready, 0);
    @(negedge clk);
    inv_en = 0;
    k = mfind(vpn, asid);
    if (k >= 0) mv[k] = 0;
  endtask

  task automatic sweep_model(input string rq);
    for (int i = 0; i < N; i++) if (mv[i]) look(mvpn[i], 12'(i * 16), masid[i], 0, 0, rq);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R9 reset rsp_valid", rsp_valid, 0);
    check(req_ready == 1, "R9 reset req_ready", req_ready, 1);
    check(fill_ready == 1, "R9 reset fill_ready", fill_ready, 1);

    // R4 / R1: fill empty buffer, nothing evicted while free slots remain
    for (int i = 0; i < N; i++) begin
      fill(key(i), 8'(i % 3), key(i) ^ 20'hA5C3E, i[0], i[1]);
      for (int j = 0; j <= i; j++) look(key(j), 12'(j * 37), 8'(j % 3), 0, 0, "R4 no eviction while free");
    end
    // R2: wrong tag misses
    for (int i = 0; i < N; i++) look(key(i), 12'h123, 8'((i + 1) % 3), 0, 0, "R2 tag mismatch");
    // R3 / R1: permission combinations
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 4; c++) look(key(i), 12'(i * 100 + c), 8'(i % 3), c[0], c[1], "R3 R1 permission");

    // R5: eviction sweep over twice the capacity
    for (int i = N - 1; i >= 0; i--) look(key(i), 12'h0, 8'(i % 3), 0, 0, "R5 reorder");
    for (int j = 0; j < N; j++) begin
      fill(key(100 + j), 8'(j % 2), 20'(j * 4099 + 5), 1, 1);
      for (int i = 0; i < N; i++) look(key(i), 12'hFFF, 8'(i % 3), 0, 0, "R5 old set");
      for (int i = 0; i < N; i++) look(key(100 + i), 12'h001, 8'(i % 2), 1, 1, "R5 new set");
    end

    // R6: overwrite an existing translation
    begin
      logic [19:0] v; logic [7:0] a;
      v = mvpn[0]; a = masid[0];
      fill(v, a, 20'hBEEF1, 1, 1);
      look(v, 12'h456, a, 1, 1, "R6 overwrite new frame");
      inval(v, a);
      look(v, 12'h456, a, 0, 0, "R6 no stale duplicate");
      sweep_model("R7 others survive invalidate");
    end

    // R7 / R4: invalidate then refill into freed slot
    inval(mvpn[3], masid[3]);
    sweep_model("R7 after second invalidate");
    fill(20'hCAFE0, 8'h77, 20'h12345, 1, 0);
    fill(20'hCAFE1, 8'h77, 20'h54321, 0, 1);
    sweep_model("R4 refill uses free slots");

    // R9: ready behaviour
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'hD0D0D; fill_asid = 8'h01; fill_pfn = 20'h0F0F0; fill_wr = 1; fill_usr = 1;
    #1 check(req_ready == 0, "R9 req_ready with fill pending", req_ready, 0);
    @(negedge clk);
    fill_valid = 0;
    begin
      int best;
      best = 0;
      for (int i = 1; i < N; i++) if (mst[i] < mst[best]) best = i;
      mv[best] = 1; mvpn[best] = 20'hD0D0D; masid[best] = 8'h01; mpfn[best] = 20'h0F0F0;
      mwr[best] = 1; musr[best] = 1; now++; mst[best] = now;
    end
    look(20'hD0D0D, 12'hABC, 8'h01, 1, 1, "R9 stalled fill lands");
    @(negedge clk);
    flush_en = 1;
    #1 check(fill_ready == 0, "R9 fill_ready during flush", fill_ready, 0);
    @(negedge clk);
    flush_en = 0;
    for (int i = 0; i < N; i++) mv[i] = 0;

    // R8: everything misses after flush
    for (int i = 0; i < N; i++) look(key(i), 12'h0, 8'(i % 3), 0, 0, "R8 flushed old");
    for (int i = 0; i < N; i++) look(key(100 + i), 12'h0, 8'(i % 2), 0, 0, "R8 flushed new");
    look(20'hD0D0D, 12'h0, 8'h01, 0, 0, "R8 flushed fill");
    fill(20'h00042, 8'h09, 20'h77777, 1, 1);
    look(20'h00042, 12'h3F0, 8'h09, 0, 1, "R8 refill after flush");

    // R10: response held under back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = {20'h00042, 12'h111}; req_asid = 8'h09;
    req_write = 0; req_user = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_hit && rsp_paddr == 32'h77777111, "R10 held response",
          {rsp_valid, rsp_hit, rsp_paddr}, {2'b11, 32'h77777111});
    check(req_ready == 0, "R10 req_ready during stall", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R10 response drained", rsp_valid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule